// File: doc/BRIEF.md
# Staged Power Domain Sequencer

This block drives the power switch and isolation controls of one switchable power domain. An off request makes the isolation barrier valid first. In the following cycle it opens every switch segment at once. An on request closes the segments one at a time, starting with the most significant segment. After each step the block holds the switch word for a programmable number of cycles, which limits inrush current. The isolation barrier is released only when the last segment has closed and its wait has run out. A one-cycle barrier-release pulse marks that moment.

The switch-control word is registered and changes by at most one step per edge. A 1 bit means the segment is off, so all ones is fully off and all zeros is fully on. Requests that arrive while a sequence runs are dropped. A request for the state the domain already has is acknowledged at once. The asynchronous active-low reset is released synchronously inside the block.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the switch word is all ones, isolation enable is 1, and busy, done and barrier-release are 0.
- R2: An off request accepted while fully on sets isolation enable at the next edge, with busy set. The switch word still reads all zeros at that point. At the following edge the switch word jumps to all ones in a single step, busy falls and done pulses.
- R3: During power-on, each step clears the highest bit that is still set. The word for step i (1..NSEG) is all ones shifted right by i, so with 8 segments it reads 0xFF, 0x7F, 0x3F down to 0x00.
- R4: Every power-on switch value, including the final all-zero value, is held for exactly WAIT_CYC cycles before the next change.
- R5: Isolation enable stays 1 while any switch bit is 1. It falls, together with a one-cycle barrier-release pulse, WAIT_CYC cycles after the word reaches zero.
- R6: Busy is 1 for the whole of a sequence. Done is a one-cycle pulse in the cycle in which busy falls.
- R7: On or off requests sampled while busy is 1 have no effect on the sequence or its timing.
- R8: An on request while fully on, or an off request while fully off, pulses done at the next edge. It leaves the switch word and isolation unchanged and does not set busy.
- R9: The first power-on step appears at the edge that samples the on request. Release follows NSEG*WAIT_CYC cycles after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| on_req_i | input | 1 | Request to power the domain up |
| off_req_i | input | 1 | Request to power the domain down |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse when a request completes |
| sw_off_o | output | NSEG | Switch-control word, 1 = segment off |
| iso_en_o | output | 1 | Isolation barrier enabled |
| bar_rel_o | output | 1 | One-cycle pulse when the barrier is released |

## Verification
A wrong step count or a misloaded wait timer shows up as a switch word that changes one cycle early or late. The bench catches this at the first affected step, because it predicts the word in every cycle of the sequence. A wrong state transition shows up as isolation released while bits are still set, or as busy and done out of phase. Such an error is visible in the cycle it happens. A request that leaks through while busy shifts every later step, so the next cycle-by-cycle compare exposes it.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ISO  = 2'd1,
    ST_WAIT = 2'd2,
    ST_ON   = 2'd3
  } pds_state_t;
endpackage

// File: rtl/pds_reset_sync.sv
module pds_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/pds_wait_timer.sv
module pds_wait_timer #(
  parameter int WAIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i | dec_i;
    cnt_d  = cnt_q;
    if (load_i)                     cnt_d = CNT_W'(WAIT_CYC);
    else if (cnt_q != '0)           cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WAIT_CYC));

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/pds_switch_reg.sv
module pds_switch_reg #(
  parameter int NSEG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_all_i,
  input  logic            step_i,
  output logic [NSEG-1:0] sw_o
);
  logic [NSEG-1:0] sw_q, sw_d;
  logic            sw_en;

  always_comb begin
    sw_en = set_all_i | step_i;
    sw_d  = sw_q;
    if (set_all_i)   sw_d = '1;
    else if (step_i) sw_d = sw_q >> 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sw_q <= '1;
    else if (sw_en) sw_q <= sw_d;
  end

  assign sw_o = sw_q;

  // R3
  sw_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_q) |-> ((sw_q == ($past(sw_q) >> 1)) || (&sw_q)));
endmodule

// File: rtl/pds_ctrl.sv
module pds_ctrl
  import pds_pkg::*;
#(
  parameter int NSEG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            on_req_i,
  input  logic            off_req_i,
  input  logic            tmr_last_i,
  input  logic [NSEG-1:0] sw_i,
  output logic            set_all_o,
  output logic            step_o,
  output logic            tmr_load_o,
  output logic            tmr_dec_o,
  output logic            iso_en_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            rel_o
);
  pds_state_t state_q, state_d;
  logic iso_q, iso_d, busy_q, busy_d, done_q, done_d, rel_q, rel_d;
  logic all_on;

  assign all_on = ~|sw_i;

  always_comb begin
    state_d    = state_q;
    iso_d      = iso_q;
    busy_d     = busy_q;
    done_d     = 1'b0;
    rel_d      = 1'b0;
    set_all_o  = 1'b0;
    step_o     = 1'b0;
    tmr_load_o = 1'b0;
    tmr_dec_o  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (on_req_i) begin
          step_o     = 1'b1;
          tmr_load_o = 1'b1;
          busy_d     = 1'b1;
          state_d    = ST_WAIT;
        end else if (off_req_i) begin
          done_d = 1'b1;
        end
      end
      ST_ON: begin
        if (off_req_i) begin
          iso_d   = 1'b1;
          busy_d  = 1'b1;
          state_d = ST_ISO;
        end else if (on_req_i) begin
          done_d = 1'b1;
        end
      end
      ST_ISO: begin
        set_all_o = 1'b1;
        busy_d    = 1'b0;
        done_d    = 1'b1;
        state_d   = ST_OFF;
      end
      ST_WAIT: begin
        if (tmr_last_i) begin
          if (all_on) begin
            iso_d   = 1'b0;
            rel_d   = 1'b1;
            done_d  = 1'b1;
            busy_d  = 1'b0;
            state_d = ST_ON;
          end else begin
            step_o     = 1'b1;
            tmr_load_o = 1'b1;
          end
        end else begin
          tmr_dec_o = 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      iso_q   <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      iso_q   <= iso_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      rel_q   <= rel_d;
    end
  end

  assign iso_en_o = iso_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign rel_o    = rel_q;

  // R5
  iso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_i) |-> iso_q);

  // R5
  rel_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_q |-> (!iso_q && all_on));

  // R2
  off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&sw_i) |-> $past(iso_q));

  // R6
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R6
  no_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !done_q);
endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
  parameter int NSEG     = 8,
  parameter int WAIT_CYC = 16
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            on_req_i,
  input  logic            off_req_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [NSEG-1:0] sw_off_o,
  output logic            iso_en_o,
  output logic            bar_rel_o
);
  logic rst_n, set_all, step, tmr_load, tmr_dec, tmr_last;
  logic [NSEG-1:0] sw;

  pds_reset_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  pds_ctrl #(.NSEG(NSEG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_req_i   (on_req_i),
    .off_req_i  (off_req_i),
    .tmr_last_i (tmr_last),
    .sw_i       (sw),
    .set_all_o  (set_all),
    .step_o     (step),
    .tmr_load_o (tmr_load),
    .tmr_dec_o  (tmr_dec),
    .iso_en_o   (iso_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rel_o      (bar_rel_o)
  );

  pds_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .dec_i  (tmr_dec),
    .last_o (tmr_last)
  );

  pds_switch_reg #(.NSEG(NSEG)) u_sw (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_all_i (set_all),
    .step_i    (step),
    .sw_o      (sw)
  );

  assign sw_off_o = sw;
endmodule

// File: tb/pwr_domain_seq_bench.sv
module pwr_domain_seq_bench;
  localparam int N = 8;
  localparam int W = 16;

  logic clk = 1'b0;
  logic arst_n, on_req, off_req;
  logic busy, done, iso, rel;
  logic [N-1:0] sw;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pwr_domain_seq #(.NSEG(N), .WAIT_CYC(W)) u_pwr_domain_seq (
    .clk       (clk),
    .arst_n    (arst_n),
    .on_req_i  (on_req),
    .off_req_i (off_req),
    .busy_o    (busy),
    .done_o    (done),
    .sw_off_o  (sw),
    .iso_en_o  (iso),
    .bar_rel_o (rel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check_all(input string tag, input logic [N-1:0] esw,
                           input logic ei, input logic eb, input logic ed, input logic er);
    chk({tag, " sw"},   32'(sw),   32'(esw));
    chk({tag, " iso"},  32'(iso),  32'(ei));
    chk({tag, " busy"}, 32'(busy), 32'(eb));
    chk({tag, " done"}, 32'(done), 32'(ed));
    chk({tag, " rel"},  32'(rel),  32'(er));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end

  initial begin
    arst_n = 1'b0; on_req = 1'b0; off_req = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 reset", {N{1'b1}}, 1'b1, 1'b0, 1'b0, 1'b0);

    // off while off
    off_req = 1'b1;
    @(negedge clk); off_req = 1'b0;
    check_all("R8 off-while-off", {N{1'b1}}, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check_all("R8 off-while-off after", {N{1'b1}}, 1'b1, 1'b0, 1'b0, 1'b0);

    // power-on sequence, stray requests injected while busy
    on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    for (int c = 0; c <= N * W; c++) begin
      if (c < N * W)
        check_all("R3 R4 R7 R9 on-seq", {N{1'b1}} >> (c / W + 1), 1'b1, 1'b1, 1'b0, 1'b0);
      else
        check_all("R5 R6 R9 release", '0, 1'b0, 1'b0, 1'b1, 1'b1);
      off_req = (c == 40) || (c == 100);
      on_req  = (c == 70);
      @(negedge clk);
      off_req = 1'b0; on_req = 1'b0;
    end
    check_all("R5 R6 post-release", '0, 1'b0, 1'b0, 1'b0, 1'b0);

    // on while on
    on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    check_all("R8 on-while-on", '0, 1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check_all("R8 on-while-on after", '0, 1'b0, 1'b0, 1'b0, 1'b0);

    // power-off sequence
    off_req = 1'b1;
    @(negedge clk); off_req = 1'b0;
    check_all("R2 off iso-first", '0, 1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check_all("R2 R6 off all-open", {N{1'b1}}, 1'b1, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check_all("R2 off settled", {N{1'b1}}, 1'b1, 1'b0, 1'b0, 1'b0);

    // second power-on with request held high throughout
    on_req = 1'b1;
    @(negedge clk);
    for (int c = 0; c < N * W; c++) begin
      chk("R3 R4 R7 held-on sw", 32'(sw), 32'({N{1'b1}} >> (c / W + 1)));
      @(negedge clk);
    end
    check_all("R5 R9 held-on release", '0, 1'b0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    check_all("R8 held-on ack", '0, 1'b0, 1'b0, 1'b1, 1'b0);
    on_req = 1'b0;
    @(negedge clk);

    // reset in the middle of a power-on
    on_req = 1'b1;
    @(negedge clk); on_req = 1'b0;
    repeat (20) @(negedge clk);
    arst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid-seq reset", {N{1'b1}}, 1'b1, 1'b0, 1'b0, 1'b0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after reset", {N{1'b1}}, 1'b1, 1'b0, 1'b0, 1'b0);

    report();
  end
endmodule